// File: doc/BRIEF.md
# Beat-Counting Data Bus Grant Arbiter

This block hands out the data bus of a split-transaction processor bus that runs with pipelined data tenures and no busy handshake. It never looks at a data-bus-busy or address-bus-busy line. It watches address tenures, each opened by a transfer-start strobe and closed by an address acknowledge. At the acknowledge it records which master owns the tenure and how many data beats it will move. Recorded tenures wait in a queue in the order of their acknowledges.

Grants are single-cycle, one-hot pulses. A pulse in cycle C means that the named master drives or samples its first data beat from cycle C+1. The arbiter finds the end of each data tenure by counting transfer-acknowledge beats against the recorded length. When the next tenure is already waiting, it fires that tenure's grant in the same cycle as the final beat, so data tenures run back to back with no idle cycle between them.

Top module: `dbarb_top`

## Requirements
- R1: `dbg_o` has at most one bit set in any cycle, and every acknowledged address tenure receives exactly one grant cycle.
- R2: The beat code of a tenure selects its length in transfer-acknowledge beats: 2'b00 = 1, 2'b01 = 2, 2'b10 = 4, 2'b11 = 8. A data tenure ends only on the beat that completes this count, and cycles without `ta_i` are wait states that do not count.
- R3: While a data tenure is in progress, the next grant is asserted only in the cycle where `ta_i` marks that tenure's final beat. The grant appears combinationally in that same cycle.
- R4: When no data tenure is in progress and a tenure is pending, its grant is asserted in that cycle.
- R5: Pending tenures are granted strictly in the order of their address acknowledges. Bit i of `dbg_o` names the master whose identifier was i.
- R6: A tenure becomes pending on the clock edge that samples its address acknowledge. Its grant can come no earlier than the cycle after the acknowledge cycle, so its data never starts before the second cycle after the acknowledge.
- R7: The master identifier and beat code are taken in the `ts_i` cycle. A `ts_i` that arrives while an address tenure is already open is ignored. An `aack_i` with no open tenure and no `ts_i` in the same cycle is ignored. `ts_i` and `aack_i` together form a one-cycle address tenure.
- R8: `ta_i` outside a data tenure, including the cycle in which an idle bus is granted, has no effect on the beat count of any later tenure.
- R9: While `rst_n` is low, all grants are deasserted. After reset the queue is empty, no tenure is in progress and no address tenure is open.
- R10: The queue holds up to `DEPTH` pending tenures. All of them are granted in order when it is filled, and an acknowledge into a full queue is a usage error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_i | input | 1 | Transfer start, opens an address tenure |
| ts_mid_i | input | MID_W | Identifier of the master starting the transfer |
| ts_code_i | input | 2 | Beat code of the transfer (see R2) |
| aack_i | input | 1 | Address acknowledge, closes the open address tenure |
| ta_i | input | 1 | Transfer acknowledge, one per data beat |
| dbg_o | output | NUM_MASTERS | One-hot, single-cycle data bus grants |

## Verification
A beat counter loaded with the wrong length, or one that counts wait states, moves a grant earlier or later by whole beats. The error is visible at `dbg_o` in the very cycle where the following tenure should have been granted. A queue that loses, duplicates or reorders an entry shows up at the next grant, either as the wrong bit or as a missing or extra pulse. A stuck "in progress" state stops all grants, and a stuck idle state lets a grant fire before the final beat. The bench compares `dbg_o` with a cycle model on every cycle, so each of these errors is reported in the cycle where it first appears.

// File: rtl/dbarb_pkg.sv
// Package dbarb_pkg
// Shared types and helpers of the beat-counting data bus arbiter.
// Assumes a two-bit beat code whose value n encodes a length of 2**n beats.
package dbarb_pkg;

    localparam int CODE_W = 2;

    typedef logic [CODE_W-1:0] beat_code_t;

    // Number of data beats carried by a tenure with the given code.
    function automatic logic [3:0] beats_of(input beat_code_t code);
        beats_of = 4'd1 << code;
    endfunction

endpackage

// File: rtl/dbarb_addr_track.sv
// Module dbarb_addr_track
// Follows address tenures opened by transfer start and closed by address
// acknowledge. At the acknowledge it emits one push carrying the owner and
// beat code of the tenure. Assumes at most one address tenure is open at a
// time. A start seen while a tenure is open is dropped.
module dbarb_addr_track
    import dbarb_pkg::*;
#(
    parameter int MID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_i,
    input  logic [MID_W-1:0] ts_mid_i,
    input  beat_code_t       ts_code_i,
    input  logic             aack_i,
    output logic             push_o,
    output logic [MID_W-1:0] push_mid_o,
    output beat_code_t       push_code_o
);

    logic             open_q;
    logic [MID_W-1:0] mid_q;
    beat_code_t       code_q;

    // Open a tenure on an accepted start and close it on the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            mid_q  <= '0;
            code_q <= '0;
        end else if (aack_i) begin
            open_q <= 1'b0;
        end else if (ts_i && !open_q) begin
            open_q <= 1'b1;
            mid_q  <= ts_mid_i;
            code_q <= ts_code_i;
        end
    end

    // The acknowledge pushes the open tenure, or a same-cycle start.
    always_comb begin
        push_o      = aack_i && (open_q || ts_i);
        push_mid_o  = open_q ? mid_q  : ts_mid_i;
        push_code_o = open_q ? code_q : ts_code_i;
    end

    AST_OPEN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        aack_i |=> !open_q); // R7
    AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        open_q && !aack_i |=> open_q && $stable(mid_q) && $stable(code_q)); // R7

endmodule

// File: rtl/dbarb_queue.sv
// Module dbarb_queue
// In-order queue of pending data tenures between the address acknowledge
// and the grant. Push and pop may occur in the same cycle. Assumes the user
// never pushes into a full queue without a pop in the same cycle.
module dbarb_queue #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q;
    logic [PTR_W-1:0] wr_q;
    logic [CNT_W-1:0] cnt_q;

    // Write the incoming entry at the tail slot.
    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[wr_q] <= push_data_i;
        end
    end

    // Advance the pointers and the occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) begin
                wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            end
            if (pop_i) begin
                rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            end
            case ({push_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Present the oldest entry and the occupancy flags.
    always_comb begin
        head_o  = mem_q[rd_q];
        empty_o = (cnt_q == '0);
        full_o  = (cnt_q == FULL);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_o |-> pop_i); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R5
    AST_FILL_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !pop_i |=> !empty_o); // R6

endmodule

// File: rtl/dbarb_tenure_ctr.sv
// Module dbarb_tenure_ctr
// Tracks the data tenure in progress by counting transfer acknowledges.
// A start loads the full beat count and marks the bus in progress from the
// next cycle. Acknowledges outside a tenure are not counted. Assumes a start
// is only requested when idle or on the final beat.
module dbarb_tenure_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] start_beats_i,
    input  logic             ta_i,
    output logic             active_o,
    output logic             last_beat_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;

    // Load on a start, otherwise count down one beat per acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= start_beats_i;
        end else if (active_q && ta_i) begin
            cnt_q    <= cnt_q - 1'b1;
            active_q <= (cnt_q != CNT_W'(1));
        end
    end

    // Expose the state to the grant decision.
    always_comb begin
        active_o    = active_q;
        last_beat_o = active_q && (cnt_q == CNT_W'(1));
    end

    AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_q && cnt_q == $past(start_beats_i)); // R2
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        active_q && !ta_i && !start_i |=> active_q && $stable(cnt_q)); // R2
    AST_IDLE_TA: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q && !start_i |=> !active_q); // R8

endmodule

// File: rtl/dbarb_grant_dec.sv
// Module dbarb_grant_dec
// Turns a grant decision and a master identifier into one-hot grant lines.
// Assumes identifiers at or above NUM_MASTERS never occur.
module dbarb_grant_dec #(
    parameter int NUM_MASTERS = 4,
    parameter int MID_W       = 2
) (
    input  logic                   fire_i,
    input  logic [MID_W-1:0]       mid_i,
    output logic [NUM_MASTERS-1:0] grant_o
);

    // One comparator per grant line.
    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_line
        assign grant_o[g] = fire_i && (mid_i == MID_W'(g));
    end

endmodule

// File: rtl/dbarb_top.sv
// Module dbarb_top
// Beat-counting data bus grant arbiter. Address tenures are queued at their
// acknowledge and granted in order with single-cycle one-hot pulses. A grant
// fires at once on an idle bus, or on the final counted beat of the tenure
// in progress. Busy lines of the bus are never used. Assumes the system keeps
// no more than DEPTH tenures pending.
module dbarb_top
    import dbarb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int DEPTH       = 4,
    parameter int MID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ts_i,
    input  logic [MID_W-1:0]       ts_mid_i,
    input  logic [1:0]             ts_code_i,
    input  logic                   aack_i,
    input  logic                   ta_i,
    output logic [NUM_MASTERS-1:0] dbg_o
);

    localparam int ENTRY_W = MID_W + CODE_W;
    localparam int CNT_W   = 4;

    logic             push;
    logic [MID_W-1:0] push_mid;
    beat_code_t       push_code;
    logic [ENTRY_W-1:0] head;
    logic             empty;
    logic             full;
    logic             active;
    logic             last_beat;
    logic             fire;
    logic [MID_W-1:0] head_mid;
    beat_code_t       head_code;

    dbarb_addr_track #(.MID_W(MID_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ts_i        (ts_i),
        .ts_mid_i    (ts_mid_i),
        .ts_code_i   (ts_code_i),
        .aack_i      (aack_i),
        .push_o      (push),
        .push_mid_o  (push_mid),
        .push_code_o (push_code)
    );

    dbarb_queue #(.W(ENTRY_W), .DEPTH(DEPTH)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i ({push_mid, push_code}),
        .pop_i       (fire),
        .head_o      (head),
        .empty_o     (empty),
        .full_o      (full)
    );

    // Split the head entry and decide whether to grant this cycle.
    always_comb begin
        {head_mid, head_code} = head;
        fire = rst_n && !empty && (!active || (last_beat && ta_i));
    end

    dbarb_tenure_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (fire),
        .start_beats_i (CNT_W'(beats_of(head_code))),
        .ta_i          (ta_i),
        .active_o      (active),
        .last_beat_o   (last_beat)
    );

    dbarb_grant_dec #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) u_dec (
        .fire_i  (fire),
        .mid_i   (head_mid),
        .grant_o (dbg_o)
    );

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dbg_o)); // R1
    AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        |dbg_o |=> active); // R2
    AST_BUSY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (|dbg_o) && active |-> ta_i); // R3
    AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !empty |-> |dbg_o); // R4
    AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        empty && push |-> dbg_o == '0); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> dbg_o == '0); // R9
    AST_FULL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push || |dbg_o); // R10

endmodule

// File: tb/tb_dbarb_top.sv
// Self-checking bench: compares dbg_o on every cycle against a cycle model
// built from the requirements, with directed phases and seeded random traffic.
module tb_dbarb_top;

    localparam int NM    = 4;
    localparam int DEPTH = 4;
    localparam int MW    = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ts;
    logic [MW-1:0] ts_mid;
    logic [1:0]    ts_code;
    logic          aack;
    logic          ta;
    logic [NM-1:0] dbg;

    int checks = 0;
    int errors = 0;
    int grants_seen = 0;
    int pushes_made = 0;

    // model state
    bit          m_open;
    int          m_open_mid;
    int          m_open_code;
    int          q_mid [16];
    int          q_code [16];
    int          q_head;
    int          q_n;
    bit          m_act;
    int          m_cnt;

    always #2.5 clk = ~clk;

    dbarb_top #(.NUM_MASTERS(NM), .DEPTH(DEPTH), .MID_W(MW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ts_i      (ts),
        .ts_mid_i  (ts_mid),
        .ts_code_i (ts_code),
        .aack_i    (aack),
        .ta_i      (ta),
        .dbg_o     (dbg)
    );

    function automatic int beats(input int code);
        return 1 << code;
    endfunction

    function automatic bit model_fire(input bit t);
        return rst_n && q_n > 0 && (!m_act || (t && m_cnt == 1));
    endfunction

    function automatic logic [NM-1:0] model_grant(input bit t);
        logic [NM-1:0] g;
        g = '0;
        if (model_fire(t)) g[q_mid[q_head]] = 1'b1;
        return g;
    endfunction

    task automatic check(input string tag, input logic [NM-1:0] act, input logic [NM-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dbg_o actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: drive, check the combinational grant, then advance the model.
    task automatic cyc(input bit r, input bit t_s, input int mid, input int code,
                       input bit a, input bit t_a, input string tag);
        logic [NM-1:0] exp;
        bit f;
        @(negedge clk);
        rst_n = r; ts = t_s; ts_mid = MW'(mid); ts_code = 2'(code); aack = a; ta = t_a;
        #1;
        exp = model_grant(t_a);
        check(tag, dbg, exp);
        if (dbg != '0) grants_seen++;
        f = model_fire(t_a);
        @(posedge clk);
        if (!r) begin
            m_open = 0; q_head = 0; q_n = 0; m_act = 0; m_cnt = 0;
        end else begin
            if (f) begin
                m_act = 1; m_cnt = beats(q_code[q_head]);
                q_head = (q_head + 1) % 16; q_n--;
            end else if (m_act && t_a) begin
                m_cnt--;
                if (m_cnt == 0) m_act = 0;
            end
            if (a && (m_open || t_s)) begin
                q_mid[(q_head + q_n) % 16]  = m_open ? m_open_mid : mid;
                q_code[(q_head + q_n) % 16] = m_open ? m_open_code : code;
                q_n++; pushes_made++;
            end
            if (a) m_open = 0;
            else if (t_s && !m_open) begin
                m_open = 1; m_open_mid = mid; m_open_code = code;
            end
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic beats_run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, 0, 0, 0, 0, tag);
            cyc(1, 0, 0, 0, 0, 1, tag);
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        rst_n = 0; ts = 0; ts_mid = 0; ts_code = 0; aack = 0; ta = 0;
        // R9: busy inputs during reset give no grant and leave nothing behind
        for (int i = 0; i < 3; i++) cyc(0, 1, 2, 1, 1, 1, "R9");
        idle(3, "R9");

        // R6 and R4: one-cycle address tenure, grant the cycle after the acknowledge
        cyc(1, 1, 1, 0, 1, 0, "R6");
        cyc(1, 0, 0, 0, 0, 0, "R4");
        cyc(1, 0, 0, 0, 0, 1, "R4");
        idle(2, "R4");

        // R2: eight-beat tenure with wait states; a two-beat tenure waits behind it
        cyc(1, 1, 2, 3, 0, 0, "R2");
        cyc(1, 0, 0, 0, 1, 0, "R2");
        cyc(1, 1, 0, 1, 1, 0, "R2");
        beats_run(8, "R2");
        beats_run(2, "R2");
        idle(2, "R2");

        // R7: second start while open is dropped; lone acknowledge is dropped
        cyc(1, 1, 3, 0, 0, 0, "R7");
        cyc(1, 1, 1, 3, 0, 0, "R7");
        cyc(1, 0, 0, 0, 1, 0, "R7");
        cyc(1, 0, 0, 0, 1, 0, "R7");
        beats_run(1, "R7");
        idle(3, "R7");

        // R8: stray acknowledges while idle, then a two-beat tenure
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 1, "R8");
        cyc(1, 1, 2, 1, 1, 1, "R8");
        cyc(1, 0, 0, 0, 0, 1, "R8");
        beats_run(2, "R8");
        idle(2, "R8");

        // R5 and R10: fill the queue behind a long tenure, then drain in order
        cyc(1, 1, 0, 3, 1, 0, "R10");
        cyc(1, 0, 0, 0, 0, 0, "R10");
        cyc(1, 1, 3, 0, 1, 0, "R5");
        cyc(1, 1, 1, 1, 1, 0, "R5");
        cyc(1, 1, 2, 0, 1, 0, "R5");
        cyc(1, 1, 0, 2, 1, 0, "R10");
        beats_run(16, "R5");
        idle(3, "R5");

        // R3: seeded random traffic, never overfilling the queue
        for (int i = 0; i < 4000; i++) begin
            bit rts, rak, rta;
            rts = ($urandom % 4) == 0;
            rak = ($urandom % 3) == 0 && q_n < DEPTH - 1;
            rta = ($urandom % 3) != 0;
            cyc(1, rts, int'($urandom % NM), int'($urandom % 4), rak, rta, "R3");
        end
        for (int i = 0; i < 80; i++) cyc(1, 0, 0, 0, 0, 1, "R3");

        // R1: every acknowledged tenure received exactly one grant cycle
        checks++;
        if (grants_seen != pushes_made) begin
            errors++;
            $display("FAIL R1: grant cycles actual %0d expected %0d", grants_seen, pushes_made);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule